// File: doc/BRIEF.md
# Dual-Clock Fall-Through Buffer with Programmable Level Flags

This block is a first-in first-out buffer (1024 words of 18 bits by default) that sits between two clock domains. The writing side presents a word with a load strobe on its own clock. The reading side consumes words with an unload strobe on a second clock. The two clocks may be unrelated, or they may be one net. The oldest stored word is always visible on the data output, so the reader needs no strobe to see the first word. A strobe only moves the head on to the next entry. The output port drives this word when output enable is high and floats otherwise.

Four status outputs follow the fill level:
- `emptyN` is active-low and shows that nothing can be read.
- `fullN` is active-low and shows that nothing can be written.
- `halfFull` is active-high and shows that at least half the depth is used.
- `almostFlag` combines almost-empty and almost-full. It is high when the level is within X of either end.

X is chosen during a reset cycle. Take the define input low: its falling edge copies the low data bits into a holding register. If define is still low when reset is released, that value becomes X. If define is high at release, X takes the default of a quarter of the depth.

Top module: `strobed_fifo`

## Requirements
- R1: Words leave in the order they entered. A word is stored on a `wrClk` rising edge with `loadEn` high and `fullN` high. The head advances on a `rdClk` rising edge with `unloadEn` high and `emptyN` high.
- R2: A load strobe while `fullN` is low changes nothing. An unload strobe while `emptyN` is low changes nothing. The stored words and their order are left intact.
- R3: While `rstN` is low over clock edges, `fullN` is 1, `emptyN` is 0, `halfFull` is 0 and `almostFlag` is 1.
- R4: After a load into an empty buffer, `emptyN` goes high and the word appears on `q` without any unload strobe.
- R5: Once the pointers have settled, `halfFull` is 1 exactly when 512 or more words are held.
- R6: Once the pointers have settled, `almostFlag` is 1 exactly when the level is at most X or at least 1024−X.
- R7: A high-to-low change of `defineN`, seen on `wrClk`, captures `dIn[8:0]`. That value becomes X only if `defineN` is low when reset is released. If `defineN` is high at release, X becomes 256. Define activity after reset has no effect on X.
- R8: With `oe` low, every bit of `q` is high impedance. With `oe` high, `q` drives the head word unchanged.
- R9: `fullN` is low whenever 1024 words are held. It falls on the edge that stores the 1024th word.
- R10: All of the above hold when `wrClk` and `rdClk` are the same signal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Load-side clock |
| rdClk | input | 1 | Unload-side clock |
| rstN | input | 1 | Synchronous active-low reset, held over edges of both clocks |
| loadEn | input | 1 | Load strobe, sampled on `wrClk` |
| dIn | input | 18 | Write data; the low 9 bits also serve as the offset value |
| defineN | input | 1 | Offset define input, active on its falling edge |
| unloadEn | input | 1 | Unload strobe, sampled on `rdClk` |
| oe | input | 1 | Output enable for `q` |
| q | output | 18 | Head word, or high impedance |
| emptyN | output | 1 | Low when nothing can be read |
| fullN | output | 1 | Low when nothing can be written |
| halfFull | output | 1 | High at 512 or more words |
| almostFlag | output | 1 | High within X of empty or of full |

## Verification
The load side knows of a store at once: `fullN`, `halfFull` and `almostFlag` all follow the edge that stores a word, and the bench samples them at the next falling edge. A store reaches `emptyN` on the unload side only after three edges: one to register the Gray pointer and two in the synchronizer. Likewise, an unload reaches the load-side flags three `wrClk` edges later. For this reason the bench checks the safety side on every strobe, sampled at the falling edge just before it: no accepted load while the model holds 1024 words, and no valid head while the model is empty. It checks exact flag levels only after several idle edges on both clocks, once every crossing has settled.

// File: rtl/strobed_fifo_pkg.sv
package strobed_fifo_pkg;
  // Strobes from control to datapath, already gated by the flags.
  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } fifoStrobe_t;
endpackage

// File: rtl/fifo_sync.sv
module fifo_sync #(
  parameter int WIDTH  = 11,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= din;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (!rstN) stage[s] <= '0;
        else       stage[s] <= stage[s-1];
      end
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/fifo_store.sv
module fifo_store
  import strobed_fifo_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 10,
  localparam int PW    = ADDR_W + 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [DATA_W-1:0] dIn,
  input  logic              oe,
  output logic [DATA_W-1:0] q,
  output logic [PW-1:0]     wrPtr,
  output logic [PW-1:0]     rdPtr
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobe.wrEn) mem[wrPtr[ADDR_W-1:0]] <= dIn;
  end

  always_ff @(posedge wrClk) begin
    if (!rstN)            wrPtr <= '0;
    else if (strobe.wrEn) wrPtr <= wrPtr + 1'b1;
  end

  always_ff @(posedge rdClk) begin
    if (!rstN)            rdPtr <= '0;
    else if (strobe.rdEn) rdPtr <= rdPtr + 1'b1;
  end

  // Fall-through: the head entry is read combinationally.
  assign q = oe ? mem[rdPtr[ADDR_W-1:0]] : {DATA_W{1'bz}};
endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
  import strobed_fifo_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int OFS_W   = 9,
  parameter int DEF_OFS = 256,
  parameter int STAGES  = 2,
  localparam int PW     = ADDR_W + 1
) (
  input  logic             wrClk,
  input  logic             rdClk,
  input  logic             rstN,
  input  logic             loadEn,
  input  logic             unloadEn,
  input  logic             defineN,
  input  logic [OFS_W-1:0] ofsIn,
  input  logic [PW-1:0]    wrPtr,
  input  logic [PW-1:0]    rdPtr,
  output fifoStrobe_t      strobe,
  output logic             emptyN,
  output logic             fullN,
  output logic             halfFull,
  output logic             almostFlag
);
  localparam logic [PW-1:0] depthLvl = PW'(1 << ADDR_W);
  localparam logic [PW-1:0] halfLvl  = PW'(1 << (ADDR_W - 1));

  function automatic logic [PW-1:0] grayToBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wrGrayQ, rdGrayQ, wrGraySync, rdGraySync;
  logic [PW-1:0] wrCount, rdCount, ofsWide;
  logic [OFS_W-1:0] ofsCapture, offset;
  logic defineQ;

  // Registered Gray copies so that only one bit changes per edge.
  always_ff @(posedge wrClk) begin
    if (!rstN) wrGrayQ <= '0;
    else       wrGrayQ <= wrPtr ^ (wrPtr >> 1);
  end

  always_ff @(posedge rdClk) begin
    if (!rstN) rdGrayQ <= '0;
    else       rdGrayQ <= rdPtr ^ (rdPtr >> 1);
  end

  fifo_sync #(.WIDTH(PW), .STAGES(STAGES)) u_rdToWr (
    .clk(wrClk), .rstN(rstN), .din(rdGrayQ), .dout(rdGraySync));
  fifo_sync #(.WIDTH(PW), .STAGES(STAGES)) u_wrToRd (
    .clk(rdClk), .rstN(rstN), .din(wrGrayQ), .dout(wrGraySync));

  // Load-side level: counts from a stale read pointer, so it may be high, never low.
  assign wrCount = wrPtr - grayToBin(rdGraySync);
  // Unload-side level: counts from a stale write pointer, so it may be low, never high.
  assign rdCount = grayToBin(wrGraySync) - rdPtr;

  assign fullN      = (wrCount != depthLvl);
  assign emptyN     = (rdCount != '0);
  assign strobe.wrEn = loadEn && fullN;
  assign strobe.rdEn = unloadEn && emptyN;

  assign ofsWide    = {{(PW-OFS_W){1'b0}}, offset};
  assign halfFull   = (wrCount >= halfLvl);
  assign almostFlag = (wrCount <= ofsWide) || (wrCount >= depthLvl - ofsWide);

  // Offset: captured on a define falling edge, committed only while in reset.
  always_ff @(posedge wrClk) begin
    defineQ <= defineN;
    if (defineQ && !defineN) ofsCapture <= ofsIn;
    if (!rstN) offset <= defineN ? OFS_W'(DEF_OFS) : ofsCapture;
  end

  a_r9_no_overflow: assert property (@(posedge wrClk) disable iff (!rstN)
    wrCount <= depthLvl)
    else $error("level above depth on load side");

  a_r2_no_underflow: assert property (@(posedge rdClk) disable iff (!rstN)
    rdCount <= depthLvl)
    else $error("read pointer passed write pointer");

  a_r1_gray_single_step: assert property (@(posedge wrClk) disable iff (!rstN)
    $past(rstN) |-> $onehot0(wrGrayQ ^ $past(wrGrayQ)))
    else $error("crossing pointer moved more than one bit");

  a_r7_offset_frozen: assert property (@(posedge wrClk) disable iff (!rstN)
    $past(rstN) |-> $stable(offset))
    else $error("offset changed outside reset");
endmodule

// File: rtl/strobed_fifo.sv
module strobed_fifo
  import strobed_fifo_pkg::*;
#(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 10,
  parameter int STAGES = 2,
  localparam int OFS_W   = ADDR_W - 1,
  localparam int DEF_OFS = 1 << (ADDR_W - 2),
  localparam int PW      = ADDR_W + 1
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [DATA_W-1:0] dIn,
  input  logic              defineN,
  input  logic              unloadEn,
  input  logic              oe,
  output logic [DATA_W-1:0] q,
  output logic              emptyN,
  output logic              fullN,
  output logic              halfFull,
  output logic              almostFlag
);
  fifoStrobe_t strobe;
  logic [PW-1:0] wrPtr, rdPtr;

  fifo_ctrl #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .DEF_OFS(DEF_OFS), .STAGES(STAGES)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .loadEn(loadEn), .unloadEn(unloadEn),
    .defineN(defineN), .ofsIn(dIn[OFS_W-1:0]), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .strobe(strobe), .emptyN(emptyN), .fullN(fullN), .halfFull(halfFull),
    .almostFlag(almostFlag));

  fifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .strobe(strobe), .dIn(dIn), .oe(oe),
    .q(q), .wrPtr(wrPtr), .rdPtr(rdPtr));
endmodule

// File: tb/test_strobed_fifo.sv
`timescale 1ns/1ps
module test_strobed_fifo;
  localparam int DEPTH = 1024;

  logic wrClk = 0, rdFree = 0, sameClk = 0;
  logic rdClk;
  logic rstN = 0, loadEn = 0, defineN = 1, unloadEn = 0, oe = 1;
  logic [17:0] dIn = '0;
  logic [17:0] q;
  logic emptyN, fullN, halfFull, almostFlag;

  always #4 wrClk = ~wrClk;
  always #5.15 rdFree = ~rdFree;
  assign rdClk = sameClk ? wrClk : rdFree;

  strobed_fifo i_strobed_fifo (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .loadEn(loadEn), .dIn(dIn),
    .defineN(defineN), .unloadEn(unloadEn), .oe(oe), .q(q), .emptyN(emptyN),
    .fullN(fullN), .halfFull(halfFull), .almostFlag(almostFlag));

  int errors = 0, checks = 0, curX = 256, wIdx = 0, rCnt = 0;
  int model[$];

  function automatic int pat(int i);
    return (i * 7919 + 13) & 18'h3FFFF;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doWrite(int v);
    bit can;
    @(negedge wrClk);
    can = fullN;
    if (model.size() == DEPTH) check(!can, "R9 fullN low at 1024 words", can, 0);
    loadEn = 1; dIn = v[17:0];
    @(posedge wrClk); #1 loadEn = 0;
    if (can) model.push_back(v);
  endtask

  task automatic doRead(bit force_);
    bit ok;
    @(negedge rdClk);
    ok = emptyN;
    if (ok) begin
      if (model.size() == 0) check(0, "R2 head valid while model empty", 1, 0);
      else check(q == model[0][17:0], "R1 head word order", q, model[0]);
    end
    if (ok || force_) begin
      unloadEn = 1;
      @(posedge rdClk); #1 unloadEn = 0;
    end
    if (ok && model.size() != 0) begin
      void'(model.pop_front());
      rCnt++;
    end
  endtask

  task automatic settle();
    repeat (8) @(posedge wrClk);
    repeat (8) @(posedge rdClk);
    #1;
  endtask

  task automatic checkFlags(string tag);
    int c = model.size();
    check(emptyN == (c != 0), {tag, " R4 emptyN"}, emptyN, c != 0);
    check(fullN == (c != DEPTH), {tag, " R9 fullN"}, fullN, c != DEPTH);
    check(halfFull == (c >= DEPTH/2), {tag, " R5 halfFull"}, halfFull, c >= DEPTH/2);
    check(almostFlag == (c <= curX || c >= DEPTH - curX), {tag, " R6 almostFlag"},
          almostFlag, c <= curX || c >= DEPTH - curX);
  endtask

  task automatic fillTo(int n);
    while (model.size() < n) begin doWrite(pat(wIdx)); wIdx++; end
  endtask

  task automatic drainTo(int n);
    while (model.size() > n) doRead(0);
  endtask

  task automatic doReset(bit useDef, int x);
    @(negedge wrClk);
    if (useDef) begin
      defineN = 1; dIn = x[17:0];
      @(negedge wrClk); defineN = 0;
      @(negedge wrClk);
    end else defineN = 1;
    rstN = 0;
    repeat (6) @(negedge wrClk);
    check(fullN == 1, "R3 fullN in reset", fullN, 1);
    check(emptyN == 0, "R3 emptyN in reset", emptyN, 0);
    check(halfFull == 0, "R3 halfFull in reset", halfFull, 0);
    check(almostFlag == 1, "R3 almostFlag in reset", almostFlag, 1);
    rstN = 1;
    model.delete();
    curX = useDef ? x : 256;
    @(negedge wrClk); defineN = 1;
    settle();
  endtask

  task automatic stream(int n, string tag);
    rCnt = 0;
    fork
      begin
        for (int i = 0; i < n; i++) begin
          doWrite(pat(wIdx)); wIdx++;
          if (i % 7 == 3) repeat (3) @(posedge wrClk);
        end
      end
      begin
        while (rCnt < n) begin
          doRead(0);
          if (rCnt % 5 == 2) repeat (2) @(posedge rdClk);
        end
      end
    join
    settle();
    checkFlags(tag);
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v;
    doReset(0, 0);
    checkFlags("after reset");

    // R4: first word falls through with no unload strobe; R8 high impedance.
    v = pat(wIdx); wIdx++;
    doWrite(v);
    settle();
    check(emptyN == 1, "R4 emptyN high after first load", emptyN, 1);
    check(q == v[17:0], "R4 first word on q without unload", q, v);
    oe = 0; #1;
    check(q === 18'bz, "R8 q floats with oe low", q, 0);
    oe = 1; #1;
    check(q == v[17:0], "R8 q drives head with oe high", q, v);

    // R5 R6 R9 level thresholds with default offset 256.
    fillTo(256); settle(); checkFlags("lvl256");
    fillTo(257); settle(); checkFlags("lvl257");
    fillTo(511); settle(); checkFlags("lvl511");
    fillTo(512); settle(); checkFlags("lvl512");
    fillTo(767); settle(); checkFlags("lvl767");
    fillTo(768); settle(); checkFlags("lvl768");
    fillTo(1024); settle(); checkFlags("lvl1024");

    // R2: loads while full are ignored.
    repeat (3) doWrite(18'h15555);
    settle(); checkFlags("full ignore R2");
    check(model.size() == DEPTH, "R2 model stays at depth", model.size(), DEPTH);

    // Drain checks order; then unloads while empty.
    drainTo(0); settle(); checkFlags("drained");
    doRead(1); doRead(1);
    settle(); checkFlags("empty unload R2");
    v = pat(wIdx); wIdx++;
    doWrite(v); settle();
    check(q == v[17:0], "R2 empty unload left head intact", q, v);
    drainTo(0);

    // R7: programmed offset 100.
    doReset(1, 100);
    fillTo(100); settle(); checkFlags("R7 ofs100 lvl100");
    fillTo(101); settle(); checkFlags("R7 ofs100 lvl101");
    @(negedge wrClk); dIn = 18'd5; defineN = 0;
    @(negedge wrClk); defineN = 1;
    fillTo(923); settle(); checkFlags("R7 ofs100 lvl923");
    fillTo(924); settle(); checkFlags("R7 ofs100 lvl924");
    drainTo(50); settle(); checkFlags("R7 late define ignored lvl50");
    check(almostFlag == 1, "R7 offset kept at 100", almostFlag, 1);

    // R7: default offset restored.
    doReset(0, 0);
    fillTo(200); settle(); checkFlags("R7 default lvl200");
    fillTo(300); settle(); checkFlags("R7 default lvl300");
    drainTo(0); settle();

    // R1: concurrent traffic, unrelated clocks.
    stream(600, "R1 async stream");

    // R10: one shared clock.
    sameClk = 1;
    doReset(0, 0);
    v = pat(wIdx); wIdx++;
    doWrite(v); settle();
    check(q == v[17:0] && emptyN, "R10 fall-through on shared clock", q, v);
    drainTo(0);
    stream(600, "R10 shared-clock stream");
    fillTo(1024); settle(); checkFlags("R10 full");
    drainTo(0); settle(); checkFlags("R10 empty");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule